// File: doc/BRIEF.md
# Low-Power Mode Wake-Up Controller

This block holds one 8-bit control register through which a microcontroller core asks to enter one of two low-power states, sleep or suspend, and names the events that may bring it back. Five event inputs feed a set of sticky flags: a reset-pin level (falling edge), an oscillator-failure pulse, an alarm pulse, a port-match pulse and a comparator level (rising edge). While the block is in a low-power state, an enabled flag, or the reset-pin flag at any time, returns it to run and raises a one-cycle wake request.

Each write loads the wake enables from the low four data bits, so any write that requests a low-power state also sets the enables. A mode request is refused while any flag is set, so software must clear the flags before it asks to sleep. A clock-gate enable output tells the oscillator logic when the low-power oscillator may stop.

Top module: `lpm_wake_ctrl`

## Requirements
- R1: After a synchronous reset, mode is run (0), rd_data is 0x00, wake_req is 0 and osc_clk_en is 1.
- R2: rd_data bits 7..5 always read 0. Bits 4..0 return the flags: bit 4 reset-pin, bit 3 oscillator-fail, bit 2 alarm, bit 1 port-match, bit 0 comparator.
- R3: In run mode with no flag set, a write with bit 7 set gives mode sleep (1) on the next cycle. A write with bit 6 set gives mode suspend (2). When both bits are set, sleep wins.
- R4: A write with bit 7 or bit 6 set is refused while any flag is 1. The mode stays run.
- R5: Each flag is set one cycle after its event, whether or not its enable is set. The events are a falling edge of pin_rst_lvl, a pulse on osc_fail_evt, alarm_evt or match_evt, and a rising edge of cmp_lvl.
- R6: A write with bit 5 set clears all flags on the next cycle. An event that arrives in the same cycle as that write still sets its flag.
- R7: In sleep or suspend, an enabled flag returns mode to run on the cycle after the flag becomes visible. wake_req is 1 for exactly that one cycle.
- R8: In a low-power mode, a set flag whose enable is 0 does not leave the mode. The reset-pin flag leaves the mode with no enable.
- R9: Every write loads the enables for bits 3..0 from wr_data bits 3..0. A request written without enable bits therefore leaves only the reset pin able to wake the block.
- R10: osc_clk_en is 0 only in sleep or suspend with every flag at 0.
- R11: Level inputs are edge detected. A comparator held high sets its flag once; after a clear, the flag stays 0 while the level stays high.
- R12: Mode request bits written while already in sleep or suspend do not change the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read data (flags) |
| pin_rst_lvl | input | 1 | Reset-pin level |
| osc_fail_evt | input | 1 | Oscillator failure pulse |
| alarm_evt | input | 1 | Alarm pulse |
| match_evt | input | 1 | Port-match pulse |
| cmp_lvl | input | 1 | Comparator output level |
| mode | output | 2 | 0 run, 1 sleep, 2 suspend |
| wake_req | output | 1 | One-cycle wake request |
| osc_clk_en | output | 1 | Low-power oscillator clock-gate enable |

## Verification
An event or level edge that is present before a clock edge shows in rd_data right after that edge. A write changes the mode, or clears the flags, on the first edge after the strobe. Leaving a low-power state takes one more edge after the flag appears, and wake_req drops again on the edge after that. The bench drives every input on the falling clock edge and samples on the falling edge that follows the expected number of rising edges. It then samples one further cycle to check that the mode holds and that wake_req has ended.

// File: rtl/lpm_wake_pkg.sv
package lpm_wake_pkg;
    localparam int REG_W     = 8;
    localparam int NUM_FLAGS = 5;
    localparam int NUM_EN    = 4;
    localparam int BIT_SLEEP = 7;
    localparam int BIT_SUSP  = 6;
    localparam int BIT_CLR   = 5;
    localparam int BIT_PIN   = 4;

    typedef enum logic [1:0] {
        MODE_RUN     = 2'd0,
        MODE_SLEEP   = 2'd1,
        MODE_SUSPEND = 2'd2
    } lpm_mode_e;

    typedef struct packed {
        lpm_mode_e mode;
        logic      wake;
    } fsm_state_t;
endpackage

// File: rtl/lpm_edge_detect.sv
module lpm_edge_detect #(
    parameter bit FALLING  = 1'b0,
    parameter bit PREV_RST = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic lvl,
    output logic hit
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d = lvl;
        if (FALLING) hit = prev_q & ~lvl;
        else         hit = ~prev_q & lvl;
    end

    always_ff @(posedge clk) begin
        if (rst) prev_q <= PREV_RST;
        else     prev_q <= prev_d;
    end
endmodule

// File: rtl/lpm_flag_bank.sv
module lpm_flag_bank #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] evt,
    input  logic         clr,
    output logic [N-1:0] flags
);
    logic [N-1:0] flags_d, flags_q;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            flags_d[i] = (flags_q[i] & ~clr) | evt[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) flags_q <= '0;
        else     flags_q <= flags_d;
    end

    assign flags = flags_q;
endmodule

// File: rtl/lpm_mode_fsm.sv
module lpm_mode_fsm
    import lpm_wake_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      req_sleep,
    input  logic      req_susp,
    input  logic      any_flag,
    input  logic      wake_hit,
    output lpm_mode_e mode_o,
    output logic      wake_o
);
    fsm_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.wake = 1'b0;
        unique case (st_q.mode)
            MODE_RUN: begin
                if (!any_flag) begin
                    if (req_sleep)     st_d.mode = MODE_SLEEP;
                    else if (req_susp) st_d.mode = MODE_SUSPEND;
                end
            end
            MODE_SLEEP, MODE_SUSPEND: begin
                if (wake_hit) begin
                    st_d.mode = MODE_RUN;
                    st_d.wake = 1'b1;
                end
            end
            default: st_d.mode = MODE_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.mode <= MODE_RUN;
            st_q.wake <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_o = st_q.mode;
    assign wake_o = st_q.wake;
endmodule

// File: rtl/lpm_wake_ctrl.sv
module lpm_wake_ctrl
    import lpm_wake_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    input  logic       pin_rst_lvl,
    input  logic       osc_fail_evt,
    input  logic       alarm_evt,
    input  logic       match_evt,
    input  logic       cmp_lvl,
    output logic [1:0] mode,
    output logic       wake_req,
    output logic       osc_clk_en
);
    localparam int PAD_W = REG_W - NUM_FLAGS;

    logic [NUM_EN-1:0]    en_d, en_q;
    logic [NUM_FLAGS-1:0] evt, flags;
    logic                 pin_fall, cmp_rise, wake_hit;
    lpm_mode_e            mode_e;

    lpm_edge_detect #(.FALLING(1'b1), .PREV_RST(1'b0)) u_pin_edge (
        .clk(clk), .rst(rst), .lvl(pin_rst_lvl), .hit(pin_fall)
    );

    lpm_edge_detect #(.FALLING(1'b0), .PREV_RST(1'b1)) u_cmp_edge (
        .clk(clk), .rst(rst), .lvl(cmp_lvl), .hit(cmp_rise)
    );

    assign evt = {pin_fall, osc_fail_evt, alarm_evt, match_evt, cmp_rise};

    lpm_flag_bank #(.N(NUM_FLAGS)) u_flags (
        .clk(clk), .rst(rst), .evt(evt),
        .clr(wr_en & wr_data[BIT_CLR]), .flags(flags)
    );

    always_comb begin
        en_d = en_q;
        if (wr_en) en_d = wr_data[NUM_EN-1:0];
        wake_hit = flags[BIT_PIN] | (|(flags[NUM_EN-1:0] & en_q));
    end

    always_ff @(posedge clk) begin
        if (rst) en_q <= '0;
        else     en_q <= en_d;
    end

    lpm_mode_fsm u_fsm (
        .clk(clk), .rst(rst),
        .req_sleep(wr_en & wr_data[BIT_SLEEP]),
        .req_susp(wr_en & wr_data[BIT_SUSP]),
        .any_flag(|flags), .wake_hit(wake_hit),
        .mode_o(mode_e), .wake_o(wake_req)
    );

    assign mode       = mode_e;
    assign rd_data    = {{PAD_W{1'b0}}, flags};
    assign osc_clk_en = (mode_e == MODE_RUN) | (|flags);
endmodule

// File: rtl/lpm_wake_ctrl_chk.sv
module lpm_wake_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input logic [7:0] rd_data,
    input logic [1:0] mode,
    input logic       wake_req
);
    p_upper_zero_r2: assert property (@(posedge clk) disable iff (rst)
        rd_data[7:5] == 3'b000);

    p_enter_sleep_r3: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'd0 && wr_en && wr_data[7] && rd_data[4:0] == 5'd0) |=> mode == 2'd1);

    p_refuse_r4: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'd0 && wr_en && (wr_data[7] || wr_data[6]) && rd_data[4:0] != 5'd0) |=> mode == 2'd0);

    p_flag_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        (rd_data[4:0] != 5'd0 && !(wr_en && wr_data[5])) |=> rd_data[4:0] != 5'd0);

    p_wake_single_r7: assert property (@(posedge clk) disable iff (rst)
        wake_req |=> !wake_req);

    p_wake_in_run_r7: assert property (@(posedge clk) disable iff (rst)
        wake_req |-> mode == 2'd0);

    p_stay_low_r12: assert property (@(posedge clk) disable iff (rst)
        (mode != 2'd0 && rd_data[4] == 1'b0 && rd_data[3:0] == 4'd0) |=> mode == $past(mode));
endmodule

bind lpm_wake_ctrl lpm_wake_ctrl_chk u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .mode(mode), .wake_req(wake_req)
);

// File: tb/lpm_wake_ctrl_tb.sv
module lpm_wake_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       pin_rst_lvl = 1'b1;
    logic       osc_fail_evt = 1'b0, alarm_evt = 1'b0, match_evt = 1'b0, cmp_lvl = 1'b0;
    logic [1:0] mode;
    logic       wake_req, osc_clk_en;
    int         total = 0, bad = 0;
    bit         done = 1'b0;

    always #10 clk = ~clk;

    lpm_wake_ctrl u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .pin_rst_lvl(pin_rst_lvl), .osc_fail_evt(osc_fail_evt), .alarm_evt(alarm_evt),
        .match_evt(match_evt), .cmp_lvl(cmp_lvl), .mode(mode), .wake_req(wake_req),
        .osc_clk_en(osc_clk_en)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic write_reg(input logic [7:0] d);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = 8'h00;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset;
        chk("R1 mode", {6'd0, mode}, 8'd0);
        chk("R1 rd_data", rd_data, 8'h00);
        chk("R1 wake_req", {7'd0, wake_req}, 8'd0);
        chk("R1 osc_clk_en", {7'd0, osc_clk_en}, 8'd1);
    endtask

    task automatic t_sleep_cmp_wake;
        write_reg(8'h81);
        chk("R3 sleep entered", {6'd0, mode}, 8'd1);
        chk("R10 osc off", {7'd0, osc_clk_en}, 8'd0);
        cmp_lvl = 1'b1;
        @(negedge clk);
        chk("R5 cmp flag", rd_data, 8'h01);
        chk("R2 upper zero", {5'd0, rd_data[7:5]}, 8'd0);
        chk("R10 osc on with flag", {7'd0, osc_clk_en}, 8'd1);
        @(negedge clk);
        chk("R7 back to run", {6'd0, mode}, 8'd0);
        chk("R7 wake pulse", {7'd0, wake_req}, 8'd1);
        @(negedge clk);
        chk("R7 wake ends", {7'd0, wake_req}, 8'd0);
        write_reg(8'h20);
        chk("R6 cleared", rd_data, 8'h00);
        idle(3);
        chk("R11 held level no reflag", rd_data, 8'h00);
        cmp_lvl = 1'b0;
        idle(1);
    endtask

    task automatic t_refuse;
        alarm_evt = 1'b1;
        @(negedge clk);
        alarm_evt = 1'b0;
        chk("R5 alarm flag w/o enable", rd_data, 8'h04);
        write_reg(8'h40);
        chk("R4 refused", {6'd0, mode}, 8'd0);
        idle(1);
        chk("R4 still run", {6'd0, mode}, 8'd0);
        write_reg(8'h20);
        write_reg(8'h44);
        chk("R3 suspend entered", {6'd0, mode}, 8'd2);
    endtask

    task automatic t_disabled_and_pin;
        match_evt = 1'b1;
        @(negedge clk);
        match_evt = 1'b0;
        chk("R5 match flag", rd_data, 8'h02);
        idle(2);
        chk("R8 disabled no wake", {6'd0, mode}, 8'd2);
        chk("R8 no wake pulse", {7'd0, wake_req}, 8'd0);
        write_reg(8'h80);
        chk("R12 request ignored", {6'd0, mode}, 8'd2);
        alarm_evt = 1'b1;
        @(negedge clk);
        alarm_evt = 1'b0;
        idle(2);
        chk("R9 alarm disabled by rewrite", {6'd0, mode}, 8'd2);
        pin_rst_lvl = 1'b0;
        @(negedge clk);
        chk("R5 pin flag", rd_data, 8'h16);
        @(negedge clk);
        chk("R8 pin wakes", {6'd0, mode}, 8'd0);
        chk("R8 pin wake pulse", {7'd0, wake_req}, 8'd1);
        pin_rst_lvl = 1'b1;
        write_reg(8'h20);
        chk("R6 all cleared", rd_data, 8'h00);
    endtask

    task automatic t_both_and_race;
        write_reg(8'hC0);
        chk("R3 sleep priority", {6'd0, mode}, 8'd1);
        osc_fail_evt = 1'b1;
        @(negedge clk);
        osc_fail_evt = 1'b0;
        idle(2);
        chk("R9 no enables after write", {6'd0, mode}, 8'd1);
        pin_rst_lvl = 1'b0;
        idle(2);
        chk("R8 pin wake", {6'd0, mode}, 8'd0);
        pin_rst_lvl = 1'b1;
        write_reg(8'h20);
        osc_fail_evt = 1'b1; wr_en = 1'b1; wr_data = 8'h20;
        @(negedge clk);
        osc_fail_evt = 1'b0; wr_en = 1'b0; wr_data = 8'h00;
        chk("R6 event kept over clear", rd_data, 8'h08);
        write_reg(8'h20);
        chk("R6 final clear", rd_data, 8'h00);
    endtask

    initial begin
        idle(4);
        rst = 1'b0;
        idle(1);
        t_reset();
        t_sleep_cmp_wake();
        t_refuse();
        t_disabled_and_pin();
        t_both_and_race();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule